// File: doc/BRIEF.md
# Overlapped Register Window File

This block is a general register file that a processor core reaches through 4-bit register names, so every routine sees 16 logical registers. Those names are mapped onto a larger physical array of 32 or 64 entries through a rotating window base. The base counts in groups of four registers. A call records how far the next window should move: zero, one, two or three groups, which is 0, 4, 8 or 12 registers. The entry operation of the called routine then moves the base forward by that recorded amount. A windowed return moves it back by the amount that the return presents. The windows of caller and callee overlap, so the caller's high registers are the callee's low registers, and arguments and results pass between routines without any copy.

The file has two combinational read ports and one write port. A write that lands in the same cycle as a read of the same logical name is forwarded to that read. Spilling registers to memory and filling them back are not done here. Instead, an occupancy bit per group tracks which groups still hold registers of live frames. The block pulses an overflow flag when an entry claims groups that an older frame still holds. It pulses an underflow flag when a return lands on a frame whose registers are no longer resident.

Top module: `wreg_file`

## Requirements
- R1: A register written through logical name L (0..15) reads back the same value through name L in the same window. The physical slot is (4·base + L) mod PHYS_REGS, and PHYS_REGS is 32 or 64.
- R2: A call with `call_v` high records `call_inc`, a group count from 0 to 3. The value stays recorded until the next call. After an entry with `entry_v` high, `win_base` equals the old base plus the recorded count, modulo the group count. A call in the same cycle as an entry takes effect only for later entries.
- R3: After a return with `ret_v` high, `win_base` equals the old base minus `ret_inc`, modulo the group count.
- R4: After a call of one group and an entry, the callee's names 2 and 3 read the values that the caller wrote to names 6 and 7. After the matching return, the caller's name 6 reads what the callee wrote to its name 2.
- R5: When `entry_v` and `ret_v` are both high, only the entry acts and the return has no effect. With neither high, `win_base` holds.
- R6: When a write and a read target the same logical name in one cycle, the read port returns the data being written.
- R7: `ovf_flag` is high for the one cycle after an entry whose newly claimed groups include a group that is still occupied. It is low otherwise. The claimed groups are base+4 up to base+3+count.
- R8: `unf_flag` is high for the one cycle after an acting return whose caller-only groups (new base up to old base−1) include an unoccupied group. It is low otherwise. The return marks the caller's groups as occupied and frees the callee-only groups.
- R9: After reset, `win_base` is 0, the recorded call count is 0, both flags are low, and groups 0 to 3 alone are occupied.
- R10: A write in the same cycle as an entry or a return goes to the window that was in effect before the rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Read port A logical name |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 4 | Read port B logical name |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write logical name |
| wr_data | input | DATA_W | Write data |
| call_v | input | 1 | Record a window increment |
| call_inc | input | 2 | Increment in groups of four (0..3) |
| entry_v | input | 1 | Advance the window by the recorded increment |
| ret_v | input | 1 | Move the window back |
| ret_inc | input | 2 | Groups to move back on a return |
| win_base | output | log2(PHYS_REGS/4) | Current window base in groups |
| ovf_flag | output | 1 | Entry overlapped a live older frame |
| unf_flag | output | 1 | Return reached a non-resident frame |

## Verification
A wrong base appears at once on `win_base` in the cycle after the rotation. Every later read then returns a value from the wrong physical slot. An occupancy bit that is set or cleared in error stays hidden until a later entry or return covers that group, which can be many calls later. The comparison therefore runs long call and return chains that wrap the array. A forwarding fault or a misrouted write shows in the same cycle on the read data, or at the first read of that name.

// File: rtl/wreg_pkg.sv
package wreg_pkg;
    localparam int unsigned LNAME_W   = 4;
    localparam int unsigned LOG_REGS  = 1 << LNAME_W;
    localparam int unsigned GRP_SIZE  = 4;
    localparam int unsigned WIN_GRPS  = LOG_REGS / GRP_SIZE;
    localparam int unsigned STEP_W    = 2;
    localparam int unsigned MAX_STEP  = (1 << STEP_W) - 1;

    typedef logic [LNAME_W-1:0] lname_t;
    typedef logic [STEP_W-1:0]  step_t;

    typedef enum logic [1:0] {
        ROT_HOLD = 2'd0,
        ROT_ADV  = 2'd1,
        ROT_BACK = 2'd2
    } rot_op_e;

    typedef struct packed {
        rot_op_e op;
        step_t   amt;
    } rot_req_t;

    function automatic rot_req_t decode_rot(logic adv, logic back,
                                            step_t pend, step_t back_amt);
        rot_req_t r;
        if (adv) begin
            r.op  = ROT_ADV;
            r.amt = pend;
        end else if (back) begin
            r.op  = ROT_BACK;
            r.amt = back_amt;
        end else begin
            r.op  = ROT_HOLD;
            r.amt = '0;
        end
        return r;
    endfunction
endpackage

// File: rtl/wreg_ptr.sv
module wreg_ptr
    import wreg_pkg::*;
#(
    parameter int unsigned NG = 16,
    parameter int unsigned BW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          call_v,
    input  step_t         call_inc,
    input  logic          entry_v,
    input  logic          ret_v,
    input  step_t         ret_inc,
    output logic [BW-1:0] base,
    output step_t         pend,
    output logic          ovf,
    output logic          unf
);
    logic [NG-1:0] occ, occ_n;
    logic [BW-1:0] base_n;
    logic          ovf_n, unf_n;
    rot_req_t      req;
    logic [NG-1:0] claim_m, caller_m, free_m;

    function automatic logic [NG-1:0] span(logic [BW-1:0] start, step_t cnt);
        logic [NG-1:0] m;
        m = '0;
        for (int i = 0; i < MAX_STEP; i++) begin
            if (i < int'(cnt))
                m[BW'(start + BW'(i))] = 1'b1;
        end
        return m;
    endfunction

    always_comb begin
        req      = decode_rot(entry_v, ret_v, pend, ret_inc);
        claim_m  = span(BW'(base + BW'(WIN_GRPS)), pend);
        caller_m = span(BW'(base - BW'(ret_inc)), ret_inc);
        free_m   = span(BW'(base - BW'(ret_inc) + BW'(WIN_GRPS)), ret_inc);
        base_n   = base;
        occ_n    = occ;
        ovf_n    = 1'b0;
        unf_n    = 1'b0;
        case (req.op)
            ROT_ADV: begin
                base_n = BW'(base + BW'(req.amt));
                ovf_n  = |(occ & claim_m);
                occ_n  = occ | claim_m;
            end
            ROT_BACK: begin
                base_n = BW'(base - BW'(req.amt));
                unf_n  = |(caller_m & ~occ);
                occ_n  = (occ & ~free_m) | caller_m;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base <= '0;
            pend <= '0;
            occ  <= NG'((1 << WIN_GRPS) - 1);
            ovf  <= 1'b0;
            unf  <= 1'b0;
        end else begin
            base <= base_n;
            occ  <= occ_n;
            ovf  <= ovf_n;
            unf  <= unf_n;
            if (call_v)
                pend <= call_inc;
        end
    end
endmodule

// File: rtl/wreg_array.sv
module wreg_array
    import wreg_pkg::*;
#(
    parameter int unsigned PHYS = 64,
    parameter int unsigned DW   = 32,
    parameter int unsigned BW   = 4,
    parameter int unsigned NRD  = 2
) (
    input  logic                    clk,
    input  logic [BW-1:0]           base,
    input  logic                    wr_en,
    input  lname_t                  wr_idx,
    input  logic [DW-1:0]           wr_data,
    input  lname_t [NRD-1:0]        rd_idx,
    output logic [NRD-1:0][DW-1:0]  rd_data
);
    localparam int unsigned PW = BW + 2;

    function automatic logic [PW-1:0] to_phys(logic [BW-1:0] b, lname_t l);
        return PW'({b, 2'b00}) + PW'(l);
    endfunction

    logic [DW-1:0] mem [PHYS];
    logic [PW-1:0] wr_phys;

    assign wr_phys = to_phys(base, wr_idx);

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_phys] <= wr_data;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic [PW-1:0] rd_phys;
        logic          fwd;
        assign rd_phys    = to_phys(base, rd_idx[p]);
        assign fwd        = wr_en && (wr_idx == rd_idx[p]);
        assign rd_data[p] = fwd ? wr_data : mem[rd_phys];
    end
endmodule

// File: rtl/wreg_file.sv
module wreg_file
    import wreg_pkg::*;
#(
    parameter int unsigned PHYS_REGS = 64,
    parameter int unsigned DATA_W    = 32,
    localparam int unsigned NG = PHYS_REGS / GRP_SIZE,
    localparam int unsigned BW = $clog2(NG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              call_v,
    input  logic [1:0]        call_inc,
    input  logic              entry_v,
    input  logic              ret_v,
    input  logic [1:0]        ret_inc,
    output logic [BW-1:0]     win_base,
    output logic              ovf_flag,
    output logic              unf_flag
);
    lname_t [1:0]             rd_idx;
    logic [1:0][DATA_W-1:0]   rd_data;
    step_t                    pend_inc;

    assign rd_idx    = {rd_b_idx, rd_a_idx};
    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];

    wreg_ptr #(.NG(NG), .BW(BW)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .call_v   (call_v),
        .call_inc (call_inc),
        .entry_v  (entry_v),
        .ret_v    (ret_v),
        .ret_inc  (ret_inc),
        .base     (win_base),
        .pend     (pend_inc),
        .ovf      (ovf_flag),
        .unf      (unf_flag)
    );

    wreg_array #(.PHYS(PHYS_REGS), .DW(DATA_W), .BW(BW), .NRD(2)) u_arr (
        .clk     (clk),
        .base    (win_base),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/wreg_file_chk.sv
module wreg_file_chk #(
    parameter int unsigned BW = 4,
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [3:0]    rd_a_idx,
    input logic [DW-1:0] rd_a_data,
    input logic [3:0]    rd_b_idx,
    input logic [DW-1:0] rd_b_data,
    input logic          wr_en,
    input logic [3:0]    wr_idx,
    input logic [DW-1:0] wr_data,
    input logic          entry_v,
    input logic          ret_v,
    input logic [1:0]    ret_inc,
    input logic [1:0]    pend_inc,
    input logic [BW-1:0] win_base,
    input logic          ovf_flag,
    input logic          unf_flag
);
    // R2
    entry_adv_chk: assert property (@(posedge clk) disable iff (rst)
        entry_v |=> win_base == BW'($past(win_base) + BW'($past(pend_inc))));

    // R3
    ret_back_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_v && !entry_v) |=> win_base == BW'($past(win_base) - BW'($past(ret_inc))));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!entry_v && !ret_v) |=> $stable(win_base));

    // R6
    fwd_a_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_a_idx == wr_idx) |-> rd_a_data == wr_data);

    // R6
    fwd_b_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_b_idx == wr_idx) |-> rd_b_data == wr_data);

    // R7
    ovf_src_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |-> $past(entry_v));

    // R8
    unf_src_chk: assert property (@(posedge clk) disable iff (rst)
        unf_flag |-> $past(ret_v && !entry_v));

    // R7
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ovf_flag, unf_flag}));
endmodule

bind wreg_file wreg_file_chk #(.BW(BW), .DW(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_a_idx  (rd_a_idx),
    .rd_a_data (rd_a_data),
    .rd_b_idx  (rd_b_idx),
    .rd_b_data (rd_b_data),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .entry_v   (entry_v),
    .ret_v     (ret_v),
    .ret_inc   (ret_inc),
    .pend_inc  (pend_inc),
    .win_base  (win_base),
    .ovf_flag  (ovf_flag),
    .unf_flag  (unf_flag)
);

// File: tb/tb_wreg_file.sv
module tb_wreg_file;
    localparam int PHYS = 64;
    localparam int NG   = PHYS / 4;
    localparam int BW   = $clog2(NG);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0]   rd_a_data, rd_b_data, wr_data = '0;
    logic          wr_en = 1'b0, call_v = 1'b0, entry_v = 1'b0, ret_v = 1'b0;
    logic [1:0]    call_inc = '0, ret_inc = '0;
    logic [BW-1:0] win_base;
    logic          ovf_flag, unf_flag;

    always #5 clk = ~clk;

    wreg_file #(.PHYS_REGS(PHYS), .DATA_W(32)) dut (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .call_v(call_v), .call_inc(call_inc),
        .entry_v(entry_v), .ret_v(ret_v), .ret_inc(ret_inc),
        .win_base(win_base), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    int n_chk = 0, n_fail = 0;
    int ovf_seen = 0, unf_seen = 0;
    bit done = 0;

    int          m_base, m_pend;
    bit          m_live [NG];
    logic [31:0] m_reg  [PHYS];
    bit          m_wr   [PHYS];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int pidx(int b, int l);
        return (b * 4 + l) % PHYS;
    endfunction

    task automatic model_reset();
        m_base = 0; m_pend = 0;
        for (int g = 0; g < NG; g++) m_live[g] = (g < 4);
        for (int i = 0; i < PHYS; i++) m_wr[i] = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wr_en = 0; call_v = 0; entry_v = 0; ret_v = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        #1;
        chk("R9 base", 32'(win_base), 32'd0);
        chk("R9 ovf", 32'(ovf_flag), 32'd0);
        chk("R9 unf", 32'(unf_flag), 32'd0);
    endtask

    task automatic step(string tag, bit we, int wi, logic [31:0] wd,
                        int ra, int rb, bit cv, int ci,
                        bit ev, bit rv, int ri);
        bit   e_ovf, e_unf;
        int   k, st;
        @(negedge clk);
        wr_en = we; wr_idx = 4'(wi); wr_data = wd;
        rd_a_idx = 4'(ra); rd_b_idx = 4'(rb);
        call_v = cv; call_inc = 2'(ci);
        entry_v = ev; ret_v = rv; ret_inc = 2'(ri);
        #1;
        if (we && wi == ra) chk({tag, " R6 rdA"}, rd_a_data, wd);
        else if (m_wr[pidx(m_base, ra)]) chk({tag, " rdA"}, rd_a_data, m_reg[pidx(m_base, ra)]);
        if (we && wi == rb) chk({tag, " R6 rdB"}, rd_b_data, wd);
        else if (m_wr[pidx(m_base, rb)]) chk({tag, " rdB"}, rd_b_data, m_reg[pidx(m_base, rb)]);
        // R10: write lands in the pre-rotation window
        if (we) begin
            m_reg[pidx(m_base, wi)] = wd;
            m_wr[pidx(m_base, wi)]  = 1;
        end
        e_ovf = 0; e_unf = 0;
        if (ev) begin
            k = m_pend;
            for (int i = 0; i < k; i++) begin
                st = (m_base + 4 + i) % NG;
                if (m_live[st]) e_ovf = 1;
                m_live[st] = 1;
            end
            m_base = (m_base + k) % NG;
        end else if (rv) begin
            k = ri;
            for (int i = 0; i < k; i++)
                m_live[(m_base - k + 4 + i + NG) % NG] = 0;
            for (int i = 0; i < k; i++) begin
                st = (m_base - k + i + NG) % NG;
                if (!m_live[st]) e_unf = 1;
                m_live[st] = 1;
            end
            m_base = (m_base - k + NG) % NG;
        end
        if (cv) m_pend = ci;
        @(posedge clk);
        #1;
        chk({tag, " R2 R3 base"}, 32'(win_base), 32'(m_base));
        chk({tag, " R7 ovf"}, 32'(ovf_flag), 32'(e_ovf));
        chk({tag, " R8 unf"}, 32'(unf_flag), 32'(e_unf));
        if (ovf_flag) ovf_seen++;
        if (unf_flag) unf_seen++;
        wr_en = 0; call_v = 0; entry_v = 0; ret_v = 0;
    endtask

    task automatic idle(string tag, int ra, int rb);
        step(tag, 0, 0, 0, ra, rb, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();

        // R1: fill one window, read back
        for (int l = 0; l < 16; l++)
            step("R1", 1, l, 32'h1000 + l, 0, 0, 0, 0, 0, 0, 0);
        for (int l = 0; l < 16; l += 2) idle("R1", l, l + 1);

        // R4: parameter passing across a 4-register rotation
        step("R4", 1, 6, 32'hAAAA0006, 0, 0, 1, 1, 0, 0, 0);
        step("R4", 1, 7, 32'hAAAA0007, 0, 0, 0, 0, 0, 0, 0);
        step("R4", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        idle("R4", 2, 3);
        chk("R4 callee L2", rd_a_data, 32'hAAAA0006);
        chk("R4 callee L3", rd_b_data, 32'hAAAA0007);
        step("R4", 1, 2, 32'hBEEF0002, 0, 0, 0, 0, 0, 0, 0);
        step("R4", 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
        idle("R4", 6, 0);
        chk("R4 caller L6", rd_a_data, 32'hBEEF0002);

        // R2: call alongside entry uses the earlier record
        step("R2", 0, 0, 0, 0, 0, 1, 2, 0, 0, 0);
        step("R2", 0, 0, 0, 0, 0, 1, 3, 1, 0, 0);
        step("R2", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        // R10: write coincident with a return and an entry
        step("R10", 1, 5, 32'hC0DE0005, 5, 0, 0, 0, 0, 1, 3);
        step("R10", 1, 9, 32'hC0DE0009, 9, 0, 1, 1, 1, 0, 0);
        idle("R10", 5, 9);
        step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1, 2);
        idle("R10", 5, 9);
        // R5: entry beats return
        step("R5", 0, 0, 0, 0, 0, 0, 0, 1, 1, 3);
        idle("R5", 1, 2);

        // R7 R8: deep chain that wraps, then unwinds past spilled frames
        do_reset();
        for (int d = 0; d < 8; d++) begin
            step("R7", 1, 0, 32'hD000 + d, 0, 0, 1, 3, 0, 0, 0);
            step("R7", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        end
        for (int d = 0; d < 8; d++)
            step("R8", 0, 0, 0, 0, 1, 0, 0, 0, 1, 3);
        chk("R7 overflow observed", 32'(ovf_seen > 0), 32'd1);
        chk("R8 underflow observed", 32'(unf_seen > 0), 32'd1);
        do_reset();
        step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
        chk("R8 return from reset", 32'(unf_flag), 32'd1);

        // mixed traffic against the model
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            int op;
            op = int'($urandom_range(0, 9));
            step("MIX", $urandom_range(0, 1) == 1, int'($urandom_range(0, 15)),
                 32'($urandom), int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
                 $urandom_range(0, 3) == 0, int'($urandom_range(0, 3)),
                 op < 2, (op == 2 || op == 3 || op == 9), int'($urandom_range(0, 3)));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule